// File: doc/BRIEF.md
# Windowed Sample Magnitude Average Detector

This block watches a stream of signed 32-bit audio samples, each qualified by a valid strobe. It groups the accepted samples into windows of either 32 or 64 samples, chosen at runtime by a one-bit select. For every sample it adds the absolute value to a running sum, so positive and negative excursions both add to the energy estimate. When a window closes, the sum is divided by the window length with a right shift. That average is compared against a programmable 32-bit threshold.

The result is a level flag. It is rewritten once per window and holds its value between window ends. It is intended as the energy half of a voice-activity detector, and it only gives meaningful results on sign-extended input samples. Dropping the enable input clears the flag and restarts the window. Changing the window select also restarts the window but leaves the flag untouched.

Top module: `wavg_detector`

## Requirements
- R1: After reset `avg_above` is 0, and no window is in progress.
- R2: With `win_long` = 0 a window closes on the 32nd accepted sample. With `win_long` = 1 it closes on the 64th accepted sample.
- R3: `sample_in` is read as two's complement and its magnitude is accumulated. A negative sample contributes its absolute value. 0x80000000 contributes 2^31.
- R4: At window close, the average is the magnitude sum shifted right by 5 bits (32-sample window) or 6 bits (64-sample window). The flag becomes 1 when that average is strictly greater than `threshold`, compared as unsigned values, and becomes 0 otherwise.
- R5: `avg_above` changes only in the cycle after the clock edge that accepts the last sample of a window. Otherwise it holds while `enable` is 1.
- R6: A cycle with `sample_valid` = 0 is ignored whatever `sample_in` carries. It neither counts toward the window nor adds to the sum.
- R7: While `enable` is 0, samples are ignored and the partial window is discarded. `avg_above` reads 0 from the cycle after `enable` is seen low.
- R8: In a cycle where `win_long` differs from its value in the previous cycle, the partial window is discarded, any sample in that cycle is ignored, and the flag holds. The next accepted sample starts a new window.
- R9: Consecutive windows are independent. Each window starts from a zero sum, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Detector enable; low clears the window and the flag |
| win_long | input | 1 | Window length select: 0 = 32 samples, 1 = 64 samples |
| sample_valid | input | 1 | `sample_in` carries a sample this cycle |
| sample_in | input | 32 | Signed sample (two's complement) |
| threshold | input | 32 | Unsigned average threshold |
| avg_above | output | 1 | Window average was above the threshold at the last window close |

## Verification
The only port that exposes internal state is `avg_above`. A wrong sample count shows up as the flag changing one or more accepted samples too early or too late, or not at all, so the bench checks the flag just before and just after each window's final sample. A wrong magnitude or a stale sum only appears at the next window close, which is at most 64 accepted samples away. Thresholds set to one below, equal to and one above the computed average turn a single unit of error into a flag miscompare. The tests of discarded samples, disable and window-select change each put large magnitudes into the state they must not touch. Any leak then moves the window close or flips the flag within the following window.

// File: rtl/wavg_pkg.sv
package wavg_pkg;

    typedef enum logic {
        WIN_SHORT = 1'b0,
        WIN_LONG  = 1'b1
    } win_sel_e;

endpackage

// File: rtl/wavg_magnitude.sv
module wavg_magnitude #(
    parameter int W = 32
) (
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] mag_o
);

    always_comb begin
        if (sample_i[W-1]) begin
            mag_o = ~sample_i + W'(1);
        end else begin
            mag_o = sample_i;
        end
    end

    // R3: a magnitude never exceeds 2^(W-1)
    always_comb begin
        assert_mag_range_R3: assert (mag_o <= (W'(1) << (W - 1)));
    end

endmodule

// File: rtl/wavg_window_ctrl.sv
module wavg_window_ctrl
    import wavg_pkg::*;
#(
    parameter int SHORT_LOG2 = 5,
    parameter int LONG_LOG2  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 sample_valid,
    input  win_sel_e             sel_i,
    output logic                 clear_o,
    output logic                 accept_o,
    output logic                 last_o,
    output win_sel_e             sel_o,
    output logic [LONG_LOG2-1:0] count_o
);

    localparam int CNT_W = LONG_LOG2;
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'((1 << SHORT_LOG2) - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'((1 << LONG_LOG2) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        win_sel_e         sel;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        sel_changed;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        sel_changed = (sel_i != st_q.sel);
        clear_o     = !enable || sel_changed;
        accept_o    = enable && sample_valid && !sel_changed;
        last_idx    = (st_q.sel == WIN_LONG) ? LAST_LONG : LAST_SHORT;
        last_o      = accept_o && (st_q.count == last_idx);

        st_d     = st_q;
        st_d.sel = sel_i;
        if (clear_o || last_o) begin
            st_d.count = '0;
        end else if (accept_o) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{count: '0, sel: WIN_SHORT};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o   = st_q.sel;
    assign count_o = st_q.count;

    // R2: a short window never counts past its last index
    assert_short_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel == WIN_SHORT) |-> (st_q.count <= LAST_SHORT));

    // R8: a window-select change restarts the count
    assert_sel_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != st_q.sel) |=> (st_q.count == '0));

    // R7: while disabled, no window progresses
    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.count == '0));

endmodule

// File: rtl/wavg_accumulator.sv
module wavg_accumulator #(
    parameter int MAG_W = 32,
    parameter int ACC_W = 38,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             accept_i,
    input  logic             last_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [ACC_W-1:0] total_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        total_o = st_q.acc + ACC_W'(mag_i);
        st_d    = st_q;
        if (clear_i) begin
            st_d.acc = '0;
        end else if (accept_i) begin
            st_d.acc = last_i ? '0 : total_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{acc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R3/R9: the sum is bounded by the samples accepted so far in this window
    assert_acc_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc <= (ACC_W'(count_i) << (MAG_W - 1)));

    // R9: the sum is empty whenever a new window begins
    assert_acc_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == '0) |-> (st_q.acc == '0));

endmodule

// File: rtl/wavg_flag_unit.sv
module wavg_flag_unit
    import wavg_pkg::*;
#(
    parameter int SAMPLE_W   = 32,
    parameter int ACC_W      = 38,
    parameter int SHORT_LOG2 = 5,
    parameter int LONG_LOG2  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                last_i,
    input  win_sel_e            sel_i,
    input  logic [ACC_W-1:0]    total_i,
    input  logic [SAMPLE_W-1:0] threshold_i,
    output logic                flag_o
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t       st_d, st_q;
    logic [ACC_W-1:0]  avg;
    logic              above;

    always_comb begin
        avg   = (sel_i == WIN_LONG) ? (total_i >> LONG_LOG2) : (total_i >> SHORT_LOG2);
        above = avg > ACC_W'(threshold_i);
        st_d  = st_q;
        if (!enable) begin
            st_d.flag = 1'b0;
        end else if (last_i) begin
            st_d.flag = above;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R7: disabled means the flag reads low on the next cycle
    assert_flag_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !flag_o);

    // R5: the flag only moves at a window close
    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !last_i) |=> $stable(flag_o));

endmodule

// File: rtl/wavg_detector.sv
module wavg_detector
    import wavg_pkg::*;
#(
    parameter int SAMPLE_W   = 32,
    parameter int SHORT_LOG2 = 5,
    parameter int LONG_LOG2  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                win_long,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [SAMPLE_W-1:0] threshold,
    output logic                avg_above
);

    localparam int CNT_W = LONG_LOG2;
    localparam int ACC_W = SAMPLE_W + LONG_LOG2;

    win_sel_e           sel_in;
    win_sel_e           sel_cur;
    logic               clear;
    logic               accept;
    logic               last;
    logic [CNT_W-1:0]   count;
    logic [SAMPLE_W-1:0] mag;
    logic [ACC_W-1:0]   total;

    assign sel_in = win_sel_e'(win_long);

    wavg_magnitude #(
        .W(SAMPLE_W)
    ) u_mag (
        .sample_i(sample_in),
        .mag_o   (mag)
    );

    wavg_window_ctrl #(
        .SHORT_LOG2(SHORT_LOG2),
        .LONG_LOG2 (LONG_LOG2)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .sample_valid(sample_valid),
        .sel_i       (sel_in),
        .clear_o     (clear),
        .accept_o    (accept),
        .last_o      (last),
        .sel_o       (sel_cur),
        .count_o     (count)
    );

    wavg_accumulator #(
        .MAG_W(SAMPLE_W),
        .ACC_W(ACC_W),
        .CNT_W(CNT_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .accept_i(accept),
        .last_i  (last),
        .mag_i   (mag),
        .count_i (count),
        .total_o (total)
    );

    wavg_flag_unit #(
        .SAMPLE_W  (SAMPLE_W),
        .ACC_W     (ACC_W),
        .SHORT_LOG2(SHORT_LOG2),
        .LONG_LOG2 (LONG_LOG2)
    ) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .last_i     (last),
        .sel_i      (sel_cur),
        .total_i    (total),
        .threshold_i(threshold),
        .flag_o     (avg_above)
    );

    // R6: a cycle without a valid strobe never advances the window
    assert_no_count_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && enable && (sel_in == sel_cur)) |=> $stable(count));

endmodule

// File: tb/wavg_detector_test.sv
`timescale 1ns/100ps
module wavg_detector_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        win_long = 1'b0;
    logic        sample_valid = 1'b0;
    logic [31:0] sample_in = '0;
    logic [31:0] threshold = '0;
    logic        avg_above;

    int  vectors = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  exp_flag = 1'b0;

    always #2.5 clk = ~clk;

    wavg_detector uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .win_long    (win_long),
        .sample_valid(sample_valid),
        .sample_in   (sample_in),
        .threshold   (threshold),
        .avg_above   (avg_above)
    );

    function automatic logic [31:0] gen(int pat, int i);
        case (pat)
            0:       return 32'(i * 1000 + 7);
            1:       return -32'(i * 12345 + 1);
            2:       return (i % 2 == 1) ? -32'(i * 50000) : 32'(i * 70000 + 3);
            3:       return 32'h8000_0000;
            4:       return 32'h7FFF_FFFF;
            default: return (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 7);
        endcase
    endfunction

    function automatic longint magof(logic [31:0] s);
        longint v;
        v = longint'($signed(s));
        return (v < 0) ? -v : v;
    endfunction

    function automatic longint avg_of(int pat, int n);
        longint sum = 0;
        for (int i = 0; i < n; i++) sum += magof(gen(pat, i));
        return sum / n;
    endfunction

    task automatic check(bit got, bit exp, string req, string what);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
        end
    endtask

    task automatic push(logic [31:0] s);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in    = s;
    endtask

    task automatic idle(logic [31:0] junk);
        @(negedge clk);
        sample_valid = 1'b0;
        sample_in    = junk;
    endtask

    // one full window: flag must hold until the last sample, then take the new verdict
    task automatic run_window(int sel, int pat, int off, bit gaps);
        int     n;
        longint avg;
        longint thr;
        bit     verdict;
        n   = (sel == 1) ? 64 : 32;
        avg = avg_of(pat, n);
        thr = avg + off;
        verdict = (avg > thr);
        @(negedge clk);
        win_long     = sel[0];
        sample_valid = 1'b0;
        threshold    = 32'(thr);
        idle(32'h0);
        for (int i = 0; i < n; i++) begin
            push(gen(pat, i));
            if (gaps && (i % 3 == 0) && (i != n - 1)) begin
                idle(32'h7FFF_FFFF);
                idle(32'h8000_0000);
                push(gen(pat, i + 1));
                i++;
            end
        end
        // last sample driven, not yet captured: flag still holds (R5, R2)
        check(avg_above, exp_flag, "R5", $sformatf("hold before close sel=%0d pat=%0d", sel, pat));
        idle(32'h0);
        check(avg_above, verdict, "R4", $sformatf("verdict sel=%0d pat=%0d off=%0d", sel, pat, off));
        exp_flag = verdict;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(avg_above, 1'b0, "R1", "flag after reset");
        enable = 1'b1;
        idle(32'h0);
        check(avg_above, 1'b0, "R1", "flag after enable");

        // sweep: both window sizes (R2), signed patterns (R3), threshold around average (R4),
        // back-to-back windows (R9)
        for (int sel = 0; sel < 2; sel++) begin
            for (int pat = 0; pat < 6; pat++) begin
                for (int off = -1; off <= 1; off++) begin
                    run_window(sel, pat, off, 1'b0);
                end
            end
        end
        check(avg_above, exp_flag, "R9", "state after sweep");

        // R6: invalid cycles carrying large values are ignored
        run_window(0, 5, 0, 1'b1);
        run_window(0, 0, -1, 1'b1);
        run_window(1, 2, 0, 1'b1);

        // R7: disabling clears the flag and ignores samples
        run_window(0, 0, -1, 1'b0);
        @(negedge clk);
        enable       = 1'b0;
        sample_valid = 1'b1;
        sample_in    = 32'h8000_0000;
        @(negedge clk);
        check(avg_above, 1'b0, "R7", "flag cleared when disabled");
        exp_flag = 1'b0;
        for (int i = 0; i < 5; i++) push(32'h8000_0000);
        check(avg_above, 1'b0, "R7", "flag stays low while disabled");
        idle(32'h0);
        enable = 1'b1;
        run_window(0, 0, 0, 1'b0);

        // R7: a partial window is discarded by a disable pulse
        for (int i = 0; i < 20; i++) push(32'h8000_0000);
        @(negedge clk);
        sample_valid = 1'b0;
        enable       = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        run_window(0, 0, -1, 1'b0);
        run_window(0, 0, 0, 1'b0);

        // R8: select change drops the partial window and the sample in that cycle
        for (int i = 0; i < 20; i++) push(32'h8000_0000);
        @(negedge clk);
        win_long     = 1'b1;
        sample_valid = 1'b1;
        sample_in    = 32'h8000_0000;
        @(negedge clk);
        sample_valid = 1'b0;
        check(avg_above, exp_flag, "R8", "flag holds across select change");
        run_window(1, 0, 0, 1'b0);
        run_window(1, 0, -1, 1'b0);

        // R8: change back to the short window mid-way
        for (int i = 0; i < 40; i++) push(32'h7FFF_FFFF);
        @(negedge clk);
        win_long     = 1'b0;
        sample_valid = 1'b1;
        sample_in    = 32'h7FFF_FFFF;
        @(negedge clk);
        sample_valid = 1'b0;
        check(avg_above, exp_flag, "R8", "flag holds across select change back");
        run_window(0, 1, 0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule